// File: doc/BRIEF.md
# Paired-register I2C 16-bit port expander

This block is an I2C target that gives a host sixteen general-purpose pins, arranged as two ports of eight. It watches its own 7-bit address on the bus. After a write address, the first byte is a command that picks one of eight internal registers. The registers are an input snapshot, an output latch, a polarity mask and a direction mask, each held once per port. Every later data byte in that write goes into the selected register. A read returns the register the last command picked.

The pointer never walks a linear map. After each data byte that is written, and after each read byte that the host acknowledges, only the lowest bit of the pointer flips. Traffic therefore alternates between the port-0 and port-1 copies of one register kind for as long as the transaction lasts. The bus lines are open-drain: the block samples SCL and SDA and can only pull SDA low. It runs on a local clock that is much faster than SCL and resynchronises every input to that clock.

Top module: `gpx16_expander`

## Requirements
- R1: A byte whose upper seven bits differ from `DEV_ADDR` is not acknowledged. The block then leaves SDA alone and changes no register until the next START.
- R2: After reset, both output latches read 0xFF and both direction masks read 0xFF, so `pin_oe_o` is 0x0000 and `pin_o` is 0xFFFF. Both polarity masks read 0x00.
- R3: The low three bits of the command select the register. 0 and 1 are input ports 0 and 1, 2 and 3 are output ports 0 and 1, 4 and 5 are polarity 0 and 1, and 6 and 7 are direction 0 and 1. Port 0 is pin bits 7:0 and port 1 is pin bits 15:8.
- R4: In a write, each data byte goes to the current register and then flips bit 0 of the pointer. Three bytes sent after command 6 land in direction 0, direction 1 and direction 0, in that order.
- R5: In a read, each byte the host acknowledges flips bit 0 of the pointer. The two ports of the selected kind come back alternately until the host does not acknowledge.
- R6: Pin bit i is an output (`pin_oe_o[i]`=1) exactly when bit i of its direction mask is 0. `pin_o[i]` always shows bit i of the output latch.
- R7: The pins are captured at the acknowledge of a read address, and reads of ports 0 and 1 return that capture XOR the polarity mask. A pin change later in the same transaction does not alter the returned bytes.
- R8: Data bytes written to commands 0 or 1 are acknowledged but change no register, pin output or output enable.
- R9: The block acknowledges its own address, the command byte and every data byte written. After a host not-acknowledge, it keeps SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the serial clock line |
| sda_i | input | 1 | Sensed level of the serial data line |
| sda_pull_o | output | 1 | When 1, pulls the data line low |
| pin_i | input | 2*PORT_W | Sensed pin levels, port 1 in the upper half |
| pin_o | output | 2*PORT_W | Output latch values driven to the pins |
| pin_oe_o | output | 2*PORT_W | Per-pin output enable, 1 = driven |

## Verification
The input snapshot is taken at the read-address acknowledge. The bench changes every pin straight after that acknowledge, in the middle of a three-byte read. Each returned byte must still match the capture made before the change, XOR the polarity mask. The register write and the pointer flip commit in the same cycle. A three-byte write to the direction pair tests this: the third byte must overwrite direction 0, visible both at `pin_oe_o` and in a read-back that wraps.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CMD_W  = 3;

   typedef enum logic [2:0] {
      L_IDLE, L_RX, L_ACK, L_TX, L_MACK
   } link_st_t;

   typedef enum logic [1:0] {
      B_ADDR, B_CMD, B_DATA
   } byte_kind_t;

   typedef enum logic [1:0] {
      GRP_IN  = 2'd0,
      GRP_OUT = 2'd1,
      GRP_POL = 2'd2,
      GRP_CFG = 2'd3
   } reg_grp_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_BIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int unsigned CHAIN_W = STAGES * W;

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {CHAIN_W{RST_BIT}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/gpx_link.sv
module gpx_link
   import gpx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h6C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              sda_pull_o,
   output logic              wr_en_o,
   output logic [CMD_W-1:0]  wr_addr_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic [CMD_W-1:0]  ptr_o,
   output logic              snap_o,
   output logic              busy_o
);
   link_st_t          st;
   byte_kind_t        kind;
   logic              scl_q, sda_q;
   logic [2:0]        bitcnt;
   logic [BYTE_W-1:0] sh, tx;
   logic              full, rw, mack_ok;
   logic [CMD_W-1:0]  ptr;

   logic scl_rise, scl_fall, bus_start, bus_stop;
   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign bus_start = scl & scl_q & sda_q & ~sda;
   assign bus_stop  = scl & scl_q & ~sda_q & sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= L_IDLE;
         kind       <= B_ADDR;
         bitcnt     <= 3'd0;
         sh         <= '0;
         tx         <= '0;
         full       <= 1'b0;
         rw         <= 1'b0;
         mack_ok    <= 1'b0;
         ptr        <= '0;
         sda_pull_o <= 1'b0;
         wr_en_o    <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
         snap_o     <= 1'b0;
      end else begin
         wr_en_o <= 1'b0;
         snap_o  <= 1'b0;
         if (bus_start) begin
            st         <= L_RX;
            kind       <= B_ADDR;
            bitcnt     <= 3'd0;
            full       <= 1'b0;
            sda_pull_o <= 1'b0;
         end else if (bus_stop) begin
            st         <= L_IDLE;
            sda_pull_o <= 1'b0;
         end else begin
            case (st)
               L_RX: begin
                  if (scl_rise) begin
                     sh     <= {sh[BYTE_W-2:0], sda};
                     bitcnt <= bitcnt + 3'd1;
                     if (bitcnt == 3'd7) full <= 1'b1;
                  end else if (scl_fall && full) begin
                     full   <= 1'b0;
                     bitcnt <= 3'd0;
                     case (kind)
                        B_ADDR: begin
                           // R1: a foreign address drops back to idle
                           if (sh[7:1] == DEV_ADDR) begin
                              rw         <= sh[0];
                              snap_o     <= sh[0];  // R7 capture point
                              sda_pull_o <= 1'b1;
                              st         <= L_ACK;
                           end else begin
                              st <= L_IDLE;
                           end
                        end
                        B_CMD: begin
                           ptr        <= sh[CMD_W-1:0];
                           sda_pull_o <= 1'b1;
                           st         <= L_ACK;
                        end
                        default: begin
                           // R4: commit and flip the pair bit together
                           wr_en_o    <= 1'b1;
                           wr_addr_o  <= ptr;
                           wr_data_o  <= sh;
                           ptr        <= {ptr[CMD_W-1:1], ~ptr[0]};
                           sda_pull_o <= 1'b1;
                           st         <= L_ACK;
                        end
                     endcase
                  end
               end
               L_ACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        tx         <= rd_data_i;
                        sda_pull_o <= ~rd_data_i[BYTE_W-1];
                        bitcnt     <= 3'd0;
                        st         <= L_TX;
                     end else begin
                        sda_pull_o <= 1'b0;
                        kind       <= (kind == B_ADDR) ? B_CMD : B_DATA;
                        st         <= L_RX;
                     end
                  end
               end
               L_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 3'd7) begin
                        sda_pull_o <= 1'b0;
                        st         <= L_MACK;
                     end else begin
                        tx         <= {tx[BYTE_W-2:0], 1'b0};
                        sda_pull_o <= ~tx[BYTE_W-2];
                        bitcnt     <= bitcnt + 3'd1;
                     end
                  end
               end
               L_MACK: begin
                  if (scl_rise) begin
                     mack_ok <= ~sda;
                     // R5: host acknowledge advances within the pair
                     if (!sda) ptr <= {ptr[CMD_W-1:1], ~ptr[0]};
                  end else if (scl_fall) begin
                     if (mack_ok) begin
                        tx         <= rd_data_i;
                        sda_pull_o <= ~rd_data_i[BYTE_W-1];
                        bitcnt     <= 3'd0;
                        st         <= L_TX;
                     end else begin
                        st <= L_IDLE;  // R9: stay released after NACK
                     end
                  end
               end
               default: st <= L_IDLE;
            endcase
         end
      end
   end

   assign ptr_o  = ptr;
   assign busy_o = (st != L_IDLE);
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
   import gpx_pkg::*;
#(
   parameter int unsigned PORT_W = 8,
   parameter int unsigned NPORT  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [CMD_W-1:0]        wr_addr,
   input  logic [PORT_W-1:0]       wr_data,
   input  logic                    snap,
   input  logic [NPORT*PORT_W-1:0] pins_i,
   input  logic [CMD_W-1:0]        rd_addr,
   output logic [PORT_W-1:0]       rd_data,
   output logic [NPORT*PORT_W-1:0] pins_o,
   output logic [NPORT*PORT_W-1:0] pins_oe
);
   logic [PORT_W-1:0] in_v  [NPORT];
   logic [PORT_W-1:0] out_v [NPORT];
   logic [PORT_W-1:0] pol_v [NPORT];
   logic [PORT_W-1:0] cfg_v [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [PORT_W-1:0] in_q, out_q, pol_q, cfg_q;
      logic              hit;
      assign hit = wr_en && (wr_addr[0] == p[0]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_q  <= '0;
            out_q <= '1;   // R2
            pol_q <= '0;
            cfg_q <= '1;   // R2: every pin an input
         end else begin
            if (snap) in_q <= pins_i[p*PORT_W +: PORT_W];
            // R8: the input group has no write path
            if (hit && reg_grp_t'(wr_addr[2:1]) == GRP_OUT) out_q <= wr_data;
            if (hit && reg_grp_t'(wr_addr[2:1]) == GRP_POL) pol_q <= wr_data;
            if (hit && reg_grp_t'(wr_addr[2:1]) == GRP_CFG) cfg_q <= wr_data;
         end
      end

      assign in_v[p]  = in_q ^ pol_q;      // R7
      assign out_v[p] = out_q;
      assign pol_v[p] = pol_q;
      assign cfg_v[p] = cfg_q;
      assign pins_o[p*PORT_W +: PORT_W]  = out_q;
      assign pins_oe[p*PORT_W +: PORT_W] = ~cfg_q;   // R6
   end

   always_comb begin
      case (reg_grp_t'(rd_addr[2:1]))
         GRP_IN:  rd_data = in_v[rd_addr[0]];
         GRP_OUT: rd_data = out_v[rd_addr[0]];
         GRP_POL: rd_data = pol_v[rd_addr[0]];
         default: rd_data = cfg_v[rd_addr[0]];
      endcase
   end
endmodule

// File: rtl/gpx16_expander.sv
module gpx16_expander
   import gpx_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h6C,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PORT_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_pull_o,
   input  logic [2*PORT_W-1:0]  pin_i,
   output logic [2*PORT_W-1:0]  pin_o,
   output logic [2*PORT_W-1:0]  pin_oe_o
);
   localparam int unsigned NPORT = 2;
   localparam int unsigned PIN_W = NPORT * PORT_W;

   initial begin
      assert (PORT_W == BYTE_W) else $error("PORT_W must equal the bus byte width");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic              scl_s, sda_s;
   logic [PIN_W-1:0]  pins_s;
   logic              wr_en, snap, busy;
   logic [CMD_W-1:0]  wr_addr, ptr;
   logic [BYTE_W-1:0] wr_data, rd_data;

   gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
   );

   gpx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pins_s)
   );

   gpx_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
      .rd_data_i(rd_data), .sda_pull_o(sda_pull_o),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .ptr_o(ptr), .snap_o(snap), .busy_o(busy)
   );

   gpx_regs #(.PORT_W(PORT_W), .NPORT(NPORT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .snap(snap), .pins_i(pins_s), .rd_addr(ptr),
      .rd_data(rd_data), .pins_o(pin_o), .pins_oe(pin_oe_o)
   );
endmodule

// File: rtl/gpx16_expander_chk.sv
module gpx16_expander_chk #(
   parameter int unsigned PIN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sda_pull_o,
   input logic [PIN_W-1:0] pin_o,
   input logic [PIN_W-1:0] pin_oe_o,
   input logic             wr_en,
   input logic [2:0]       wr_addr,
   input logic [2:0]       ptr,
   input logic             busy
);
   // R9: no pull on the data line while the link is idle
   a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_pull_o);

   // R6: output enables move only after a direction write
   a_r6_oe_by_config: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe_o) |-> ($past(wr_en) && $past(wr_addr[2:1]) == 2'b11));

   // R8: writes aimed at the input pair leave the pins alone
   a_r8_input_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[2:1] == 2'b00) |=> ($stable(pin_o) && $stable(pin_oe_o)));

   // R4: after a committed byte the pointer is the partner register
   a_r4_pair_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr[2:1] == wr_addr[2:1] && ptr[0] != wr_addr[0]));
endmodule

bind gpx16_expander gpx16_expander_chk #(.PIN_W(2*PORT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .pin_o(pin_o),
   .pin_oe_o(pin_oe_o), .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr),
   .busy(busy)
);

// File: tb/gpx16_expander_tb.sv
`timescale 1ns/1ps
module gpx16_expander_tb;
   localparam logic [6:0] DEV = 7'h6C;
   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        tb_pull = 1'b0;
   logic        dut_pull;
   logic        sda;
   logic [15:0] pin_i = 16'h0000;
   logic [15:0] pin_o, pin_oe;
   logic        addr_r_done = 1'b0;
   logic        done = 1'b0;
   int          n_chk = 0;
   int          n_err = 0;

   logic [7:0]  exp_q [$];
   string       tag_q [$];
   logic [7:0]  got_q [$];

   always #10 clk = ~clk;
   assign sda = ~(tb_pull | dut_pull);

   gpx16_expander #(.DEV_ADDR(DEV)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .sda_pull_o(dut_pull), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (got_q.size() > 0) begin
         logic [7:0] g;
         g = got_q.pop_front();
         if (exp_q.size() == 0) check("read byte with no expectation", {8'h00, g}, 16'hXXXX);
         else check(tag_q.pop_front(), {8'h00, g}, {8'h00, exp_q.pop_front()});
      end
   end

   task automatic push_exp(input logic [7:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic w();  repeat (Q)   @(negedge clk); endtask
   task automatic hw(); repeat (Q/2) @(negedge clk); endtask

   task automatic i2c_start();
      tb_pull = 1'b0; w(); scl = 1'b1; w(); tb_pull = 1'b1; w(); scl = 1'b0; hw();
   endtask

   task automatic i2c_stop();
      tb_pull = 1'b1; w(); scl = 1'b1; w(); tb_pull = 1'b0; w();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         tb_pull = ~b[i]; w(); scl = 1'b1; w(); scl = 1'b0; hw();
      end
      tb_pull = 1'b0; w(); scl = 1'b1; hw(); ack = ~sda; hw(); scl = 1'b0; hw();
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      tb_pull = 1'b0;
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
         w(); scl = 1'b1; hw(); b = {b[6:0], sda}; hw(); scl = 1'b0; hw();
      end
      tb_pull = mack; w(); scl = 1'b1; w(); scl = 1'b0; hw(); tb_pull = 1'b0;
   endtask

   task automatic do_write(input logic [6:0] addr, input logic [7:0] cmd,
                           input logic [23:0] dw, input int n);
      logic a;
      logic mine;
      mine = (addr == DEV);
      i2c_start();
      send_byte({addr, 1'b0}, a);
      check(mine ? "R9 address ack" : "R1 foreign address nack", {15'd0, a}, {15'd0, mine});
      send_byte(cmd, a);
      check(mine ? "R9 command ack" : "R1 command ignored", {15'd0, a}, {15'd0, mine});
      for (int i = 0; i < n; i++) begin
         send_byte(dw[23-8*i -: 8], a);
         check(mine ? "R9 data ack" : "R1 data ignored", {15'd0, a}, {15'd0, mine});
      end
      i2c_stop();
   endtask

   task automatic do_read(input logic [7:0] cmd, input int n);
      logic a;
      logic [7:0] b;
      i2c_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(cmd, a);
      i2c_start();
      send_byte({DEV, 1'b1}, a);
      check("R9 read address ack", {15'd0, a}, 16'd1);
      addr_r_done = 1'b1;
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         got_q.push_back(b);
      end
      w();
      check("R9 released after host nack", {15'd0, dut_pull}, 16'd0);
      i2c_stop();
      addr_r_done = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2 reset state at the pins
      check("R2 reset pin_o", pin_o, 16'hFFFF);
      check("R2 reset pin_oe", pin_oe, 16'h0000);
      check("R2 reset sda released", {15'd0, dut_pull}, 16'd0);

      // R2 and R3: read back reset values per pair
      push_exp(8'hFF, "R2 R3 output port 0"); push_exp(8'hFF, "R2 R3 output port 1");
      do_read(8'h02, 2);
      push_exp(8'h00, "R2 R3 polarity 0"); push_exp(8'h00, "R2 R3 polarity 1");
      do_read(8'h04, 2);
      push_exp(8'hFF, "R2 R3 direction 1"); push_exp(8'hFF, "R2 R3 direction 0");
      do_read(8'h07, 2);

      // R4: three bytes into the direction pair wrap back to port 0
      do_write(DEV, 8'h06, 24'h12_34_0F, 3);
      check("R4 R6 pin_oe after wrapped write", pin_oe, ~16'h340F);
      push_exp(8'h0F, "R5 direction 0"); push_exp(8'h34, "R5 direction 1");
      push_exp(8'h0F, "R5 direction 0 again");
      do_read(8'h06, 3);

      // R6: output latches reach pin_o
      do_write(DEV, 8'h02, 24'hA5_3C_00, 2);
      check("R6 pin_o from output latches", pin_o, 16'h3CA5);
      check("R6 pin_oe unchanged by output write", pin_oe, ~16'h340F);

      // R7: snapshot with polarity, pin change after address ack
      pin_i = 16'h5AC3;
      do_write(DEV, 8'h04, 24'hFF_00_00, 2);
      push_exp(8'h3C, "R7 input 0 inverted"); push_exp(8'h5A, "R7 input 1");
      push_exp(8'h3C, "R7 R5 input 0 after wrap");
      fork
         do_read(8'h00, 3);
         begin
            wait (addr_r_done);
            pin_i = 16'h0000;
         end
      join
      push_exp(8'h00, "R7 R3 input 1 fresh snapshot"); push_exp(8'hFF, "R7 input 0 fresh snapshot");
      do_read(8'h01, 2);

      // R8: writes to the input pair are acknowledged and inert
      do_write(DEV, 8'h00, 24'h11_22_00, 2);
      check("R8 pin_o unchanged", pin_o, 16'h3CA5);
      check("R8 pin_oe unchanged", pin_oe, ~16'h340F);
      push_exp(8'hFF, "R8 input 0 not overwritten"); push_exp(8'h00, "R8 input 1 not overwritten");
      do_read(8'h00, 2);

      // R1: foreign address is ignored
      do_write(7'h6D, 8'h02, 24'h00_00_00, 2);
      check("R1 pin_o unchanged by foreign write", pin_o, 16'h3CA5);
      check("R1 sda released", {15'd0, dut_pull}, 16'd0);
      push_exp(8'hA5, "R1 output 0 intact"); push_exp(8'h3C, "R1 output 1 intact");
      do_read(8'h02, 2);

      repeat (10) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 16'd0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule